// File: doc/BRIEF.md
# Programmable PLA Mealy sequencer

This block is the next-state logic of a field-configurable sequencer. A programmable AND plane forms 64 product terms over 16 external inputs, 8 state-register feedback bits and 2 complement signals. A programmable OR plane then routes those terms to separate J and K command columns for 8 state registers and 8 output registers. The J-K register bank sits outside this block. It feeds its state bits back on `st_fb` and acts on the J/K commands produced here. Because the commands depend on both the current inputs and the current state, the machine is of the Mealy type.

Each complement signal is high when none of the product terms selected for it is active. A single term that tests a complement signal therefore acts as the ELSE branch of a group of conditions. Configuration is loaded one term per word over an address/data port while a load-enable input is high.

A small controller FSM gates the OR plane. Its states are:

- `ST_BLANK`: reached from reset; nothing has been loaded yet.
- `ST_LOAD`: configuration is in progress.
- `ST_RUN`: commands are live.

Its transitions are:

- blank-to-load when `cfg_load_en` is high.
- load-to-run when `cfg_load_en` is low.
- run-to-load when `cfg_load_en` is high again.

Top module: `plas_sequencer`

## Requirements
- R1: For each of the 26 variables, a term holds two bits, a true-enable and a complement-enable. With only the true-enable set, the term needs the variable at 1. With only the complement-enable set, it needs the variable at 0. With both clear, the variable is don't care. With both set, the term is always false. A term with no enable bits set is true.
- R2: Variable index 0..15 is `ext_in[0..15]`, index 16..23 is `st_fb[0..7]` and index 24..25 is complement signal 0..1.
- R3: OR column 2r is the J command and column 2r+1 is the K command of register r. Registers 0..7 are the state registers (`st_j`/`st_k`) and registers 8..15 are the output registers (`out_j`/`out_k`). A command is high when any active term is connected to its column.
- R4: `cmp_q[c]` is high exactly when no term whose select bit c is set is true over its input and feedback literals; the complement literals of the selected terms are ignored for this. All terms then use the current `cmp_q` values for indices 24..25.
- R5: A configuration word is stored in term `cfg_addr` at a rising clock edge where both `cfg_load_en` and `cfg_we` are high. The word layout is: bits [25:0] true-enables, [51:26] complement-enables, [83:52] OR columns, [85:84] complement selects. A write with `cfg_load_en` low is ignored.
- R6: All J/K commands are 0 in the following cases: from reset until the end of the first load, while `cfg_load_en` is high, and in the cycle after it falls.
- R7: Synchronous reset clears every configuration word, so `cmp_q` reads 2'b11 and all J/K commands read 0 after reset.
- R8: Outputs are combinational in `ext_in` and `st_fb`: a change is visible in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| ext_in | input | 16 | external input variables |
| st_fb | input | 8 | state register feedback |
| cfg_load_en | input | 1 | configuration load enable |
| cfg_we | input | 1 | configuration word write strobe |
| cfg_addr | input | 6 | product-term index being written |
| cfg_wdata | input | 86 | configuration word for one term |
| st_j | output | 8 | J commands of state registers |
| st_k | output | 8 | K commands of state registers |
| out_j | output | 8 | J commands of output registers |
| out_k | output | 8 | K commands of output registers |
| cmp_q | output | 2 | complement-array signals |

## Verification
The bench builds the block with its default sizes: 16 inputs, 8 feedback bits, 2 complement signals and 64 terms. At these sizes, every OR column and every variable index (including both complement literals) is reachable by directed words. Those directed words cover the always-true term, the forced-false term and an IF/ELSE pair built on complement 0. Random configurations of all 64 terms, with occasional reloads in mid-run, then exercise the load gating and the term-level interaction between complement signals and terms.

// File: rtl/plas_pkg.sv
`timescale 1ns/1ps
package plas_pkg;
    localparam int N_IN   = 16;
    localparam int N_FB   = 8;
    localparam int N_OUT  = 8;
    localparam int N_CMP  = 2;
    localparam int N_TERM = 64;
    localparam int N_LO   = N_IN + N_FB;
    localparam int N_VAR  = N_LO + N_CMP;
    localparam int N_REG  = N_FB + N_OUT;
    localparam int N_COL  = 2 * N_REG;
    localparam int W_WORD = 2 * N_VAR + N_COL + N_CMP;
    localparam int W_ADDR = $clog2(N_TERM);

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } ctl_state_e;

    // one configuration word per product term (R5 layout, MSB first)
    typedef struct packed {
        logic [N_CMP-1:0] cmp_sel;
        logic [N_COL-1:0] or_col;
        logic [N_VAR-1:0] lit_neg;
        logic [N_VAR-1:0] lit_pos;
    } term_cfg_t;
endpackage

// File: rtl/plas_ctrl.sv
`timescale 1ns/1ps
module plas_ctrl
    import plas_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    output logic plane_en
);
    ctl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BLANK;
        else     state_q <= state_d;
    end

    // transitions and outputs (R6 gating)
    always_comb begin
        state_d  = state_q;
        plane_en = 1'b0;
        unique case (state_q)
            ST_BLANK: if (load_en) state_d = ST_LOAD;
            ST_LOAD:  if (!load_en) state_d = ST_RUN;
            ST_RUN: begin
                if (load_en) state_d = ST_LOAD;
                else         plane_en = 1'b1;
            end
            default: state_d = ST_BLANK;
        endcase
    end
endmodule

// File: rtl/plas_cfg_store.sv
`timescale 1ns/1ps
module plas_cfg_store
    import plas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [W_ADDR-1:0] wr_addr,
    input  term_cfg_t         wr_word,
    output term_cfg_t         cfg_q [N_TERM]
);
    // R5 write, R7 clear
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < N_TERM; t++) cfg_q[t] <= '0;
        end else if (wr_en) begin
            cfg_q[wr_addr] <= wr_word;
        end
    end
endmodule

// File: rtl/plas_and_plane.sv
`timescale 1ns/1ps
module plas_and_plane
    import plas_pkg::*;
(
    input  logic [N_IN-1:0]   ext_in,
    input  logic [N_FB-1:0]   st_fb,
    input  logic [N_VAR-1:0]  lit_pos [N_TERM],
    input  logic [N_VAR-1:0]  lit_neg [N_TERM],
    input  logic [N_CMP-1:0]  cmp_sel [N_TERM],
    output logic [N_TERM-1:0] term_hit,
    output logic [N_CMP-1:0]  cmp_q
);
    logic [N_LO-1:0]   v_lo;
    logic [N_TERM-1:0] base_ok;
    logic [N_TERM-1:0] cmp_ok;
    logic [N_TERM-1:0] sel_t [N_CMP];

    assign v_lo = {st_fb, ext_in};  // R2 index order

    always_comb begin
        for (int c = 0; c < N_CMP; c++)
            for (int t = 0; t < N_TERM; t++)
                sel_t[c][t] = cmp_sel[t][c];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // R1 literal match over inputs and feedback
        assign base_ok[t] = ~|((lit_pos[t][N_LO-1:0] & ~v_lo) |
                               (lit_neg[t][N_LO-1:0] &  v_lo));
        // complement literals, evaluated against the current complement signals
        assign cmp_ok[t]  = ~|((lit_pos[t][N_VAR-1:N_LO] & ~cmp_q) |
                               (lit_neg[t][N_VAR-1:N_LO] &  cmp_q));
        assign term_hit[t] = base_ok[t] & cmp_ok[t];
    end

    // R4 complement = NOR of selected terms
    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        assign cmp_q[c] = ~|(base_ok & sel_t[c]);
    end
endmodule

// File: rtl/plas_or_plane.sv
`timescale 1ns/1ps
module plas_or_plane
    import plas_pkg::*;
(
    input  logic [N_TERM-1:0] term_hit,
    input  logic [N_COL-1:0]  or_col [N_TERM],
    input  logic              plane_en,
    output logic [N_REG-1:0]  j_vec,
    output logic [N_REG-1:0]  k_vec
);
    logic [N_COL-1:0] col_any;

    always_comb begin
        col_any = '0;
        for (int t = 0; t < N_TERM; t++)
            if (term_hit[t]) col_any = col_any | or_col[t];
    end

    // R3 column pairing, R6 gating
    for (genvar r = 0; r < N_REG; r++) begin : g_reg
        assign j_vec[r] = plane_en & col_any[2*r];
        assign k_vec[r] = plane_en & col_any[2*r+1];
    end
endmodule

// File: rtl/plas_sequencer.sv
`timescale 1ns/1ps
module plas_sequencer
    import plas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   ext_in,
    input  logic [N_FB-1:0]   st_fb,
    input  logic              cfg_load_en,
    input  logic              cfg_we,
    input  logic [W_ADDR-1:0] cfg_addr,
    input  logic [W_WORD-1:0] cfg_wdata,
    output logic [N_FB-1:0]   st_j,
    output logic [N_FB-1:0]   st_k,
    output logic [N_OUT-1:0]  out_j,
    output logic [N_OUT-1:0]  out_k,
    output logic [N_CMP-1:0]  cmp_q
);
    term_cfg_t                cfg_q [N_TERM];
    logic [N_VAR-1:0]         lit_pos [N_TERM];
    logic [N_VAR-1:0]         lit_neg [N_TERM];
    logic [N_CMP-1:0]         cmp_sel [N_TERM];
    logic [N_COL-1:0]         or_col [N_TERM];
    logic [N_TERM*W_WORD-1:0] cfg_flat;
    logic                     plane_en;
    logic [N_TERM-1:0]        term_hit;
    logic [N_REG-1:0]         j_vec;
    logic [N_REG-1:0]         k_vec;

    plas_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load_en  (cfg_load_en),
        .plane_en (plane_en)
    );

    plas_cfg_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_load_en & cfg_we),
        .wr_addr (cfg_addr),
        .wr_word (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    for (genvar t = 0; t < N_TERM; t++) begin : g_split
        assign lit_pos[t] = cfg_q[t].lit_pos;
        assign lit_neg[t] = cfg_q[t].lit_neg;
        assign cmp_sel[t] = cfg_q[t].cmp_sel;
        assign or_col[t]  = cfg_q[t].or_col;
        assign cfg_flat[t*W_WORD +: W_WORD] = cfg_q[t];
    end

    plas_and_plane u_and (
        .ext_in   (ext_in),
        .st_fb    (st_fb),
        .lit_pos  (lit_pos),
        .lit_neg  (lit_neg),
        .cmp_sel  (cmp_sel),
        .term_hit (term_hit),
        .cmp_q    (cmp_q)
    );

    plas_or_plane u_or (
        .term_hit (term_hit),
        .or_col   (or_col),
        .plane_en (plane_en),
        .j_vec    (j_vec),
        .k_vec    (k_vec)
    );

    assign st_j  = j_vec[N_FB-1:0];
    assign st_k  = k_vec[N_FB-1:0];
    assign out_j = j_vec[N_REG-1:N_FB];
    assign out_k = k_vec[N_REG-1:N_FB];
endmodule

// File: rtl/plas_sequencer_chk.sv
`timescale 1ns/1ps
module plas_sequencer_chk
    import plas_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_load_en,
    input logic                     cfg_we,
    input logic [N_FB-1:0]          st_j,
    input logic [N_FB-1:0]          st_k,
    input logic [N_OUT-1:0]         out_j,
    input logic [N_OUT-1:0]         out_k,
    input logic [N_CMP-1:0]         cmp_q,
    input logic [N_TERM*W_WORD-1:0] cfg_flat
);
    logic seen_wr;

    always_ff @(posedge clk) begin
        if (rst)                      seen_wr <= 1'b0;
        else if (cfg_load_en && cfg_we) seen_wr <= 1'b1;
    end

    a_r6_quiet_load: assert property (@(posedge clk) disable iff (rst)
        cfg_load_en |-> ({st_j, st_k, out_j, out_k} == '0));

    a_r6_quiet_gap: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_load_en) |-> ({st_j, st_k, out_j, out_k} == '0));

    a_r5_write_gated: assert property (@(posedge clk) disable iff (rst)
        !cfg_load_en |=> $stable(cfg_flat));

    a_r7_cmp_idle: assert property (@(posedge clk) disable iff (rst)
        !seen_wr |-> (cmp_q == '1));
endmodule

bind plas_sequencer plas_sequencer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_load_en (cfg_load_en),
    .cfg_we      (cfg_we),
    .st_j        (st_j),
    .st_k        (st_k),
    .out_j       (out_j),
    .out_k       (out_k),
    .cmp_q       (cmp_q),
    .cfg_flat    (cfg_flat)
);

// File: tb/sim_plas_sequencer.sv
`timescale 1ns/1ps
module sim_plas_sequencer;
    import plas_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_IN-1:0]   ext_in = '0;
    logic [N_FB-1:0]   st_fb = '0;
    logic              cfg_load_en = 1'b0;
    logic              cfg_we = 1'b0;
    logic [W_ADDR-1:0] cfg_addr = '0;
    logic [W_WORD-1:0] cfg_wdata = '0;
    logic [N_FB-1:0]   st_j, st_k;
    logic [N_OUT-1:0]  out_j, out_k;
    logic [N_CMP-1:0]  cmp_q;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R7";

    // reference model state
    logic [W_WORD-1:0] m_cfg [N_TERM];
    bit m_seen = 0;
    bit m_run = 0;

    always #2.5 clk = ~clk;

    plas_sequencer u0 (
        .clk(clk), .rst(rst), .ext_in(ext_in), .st_fb(st_fb),
        .cfg_load_en(cfg_load_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .st_j(st_j), .st_k(st_k), .out_j(out_j),
        .out_k(out_k), .cmp_q(cmp_q)
    );

    logic [33:0] dut_vec;
    assign dut_vec = {cmp_q, out_k, out_j, st_k, st_j};

    function automatic logic [W_WORD-1:0] mk(logic [N_VAR-1:0] lp, logic [N_VAR-1:0] ln,
                                             logic [N_COL-1:0] oc, logic [N_CMP-1:0] sl);
        return {sl, oc, ln, lp};
    endfunction

    function automatic logic [W_WORD-1:0] rnd_word();
        logic [W_WORD-1:0] w = '0;
        for (int i = 0; i < N_VAR; i++) begin
            int r = int'($urandom % 64);
            if (r < 4)       w[i] = 1'b1;
            else if (r < 8)  w[N_VAR + i] = 1'b1;
            else if (r == 8) begin w[i] = 1'b1; w[N_VAR + i] = 1'b1; end
        end
        for (int c = 0; c < N_COL; c++)
            if ($urandom % 8 == 0) w[2*N_VAR + c] = 1'b1;
        for (int c = 0; c < N_CMP; c++)
            if ($urandom % 8 == 0) w[2*N_VAR + N_COL + c] = 1'b1;
        return w;
    endfunction

    function automatic logic [33:0] model_eval();
        bit base [N_TERM];
        bit hit;
        bit ecmp [N_CMP];
        bit colv [N_COL];
        logic [33:0] v = '0;
        for (int c = 0; c < N_COL; c++) colv[c] = 0;
        for (int t = 0; t < N_TERM; t++) begin
            base[t] = 1;
            for (int i = 0; i < N_LO; i++) begin
                bit val = (i < N_IN) ? ext_in[i] : st_fb[i - N_IN];
                if ((m_cfg[t][i] && !val) || (m_cfg[t][N_VAR + i] && val)) base[t] = 0;
            end
        end
        for (int c = 0; c < N_CMP; c++) begin
            ecmp[c] = 1;
            for (int t = 0; t < N_TERM; t++)
                if (base[t] && m_cfg[t][2*N_VAR + N_COL + c]) ecmp[c] = 0;
        end
        for (int t = 0; t < N_TERM; t++) begin
            hit = base[t];
            for (int i = N_LO; i < N_VAR; i++) begin
                bit val = ecmp[i - N_LO];
                if ((m_cfg[t][i] && !val) || (m_cfg[t][N_VAR + i] && val)) hit = 0;
            end
            if (hit)
                for (int c = 0; c < N_COL; c++)
                    if (m_cfg[t][2*N_VAR + c]) colv[c] = 1;
        end
        if (m_run && !cfg_load_en) begin
            for (int r = 0; r < N_FB; r++) begin
                v[r]      = colv[2*r];
                v[8 + r]  = colv[2*r + 1];
                v[16 + r] = colv[2*(r + N_FB)];
                v[24 + r] = colv[2*(r + N_FB) + 1];
            end
        end
        v[32] = ecmp[0];
        v[33] = ecmp[1];
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < N_TERM; t++) m_cfg[t] = '0;
            m_seen = 0;
            m_run = 0;
        end else begin
            if (cfg_load_en && cfg_we) m_cfg[cfg_addr] = cfg_wdata;
            if (cfg_load_en) begin m_seen = 1; m_run = 0; end
            else m_run = m_seen;
        end
    end

    // compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [33:0] e;
            e = model_eval();
            total++;
            if (dut_vec[31:0] !== e[31:0]) begin
                bad++;
                $display("FAIL %s jk got=%h exp=%h", cur_req, dut_vec[31:0], e[31:0]);
            end
            total++;
            if (dut_vec[33:32] !== e[33:32]) begin
                bad++;
                $display("FAIL %s cmp got=%b exp=%b", cur_req, dut_vec[33:32], e[33:32]);
            end
        end
    end

    task automatic chk(string req, logic [33:0] got, logic [33:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R6 got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #2;
        chk("R7", dut_vec, {2'b11, 32'h0});

        // directed load; R6 quiet while loading
        tick();
        cur_req = "R6";
        cfg_load_en = 1'b1;
        #2;
        chk("R6", dut_vec[31:0], 34'h0);
        tick(); cfg_we = 1; cfg_addr = 0; cfg_wdata = mk(0, 0, 32'h1, 0);
        tick(); cfg_addr = 1; cfg_wdata = mk(26'h8, 26'h8, 32'h2, 0);
        tick(); cfg_addr = 2; cfg_wdata = mk(26'h1 << 16, 26'h1, 32'h1 << 16, 0);
        tick(); cfg_addr = 3; cfg_wdata = mk(26'h20, 0, 0, 2'b01);
        tick(); cfg_addr = 4; cfg_wdata = mk(26'h1 << 24, 0, 32'h1 << 23, 0);
        tick(); cfg_addr = 5; cfg_wdata = mk(26'h20, 26'h1 << 24, 32'h1 << 22, 0);
        #2;
        chk("R6", {2'b00, dut_vec[31:0]}, 34'h0);
        tick(); cfg_we = 0; cfg_load_en = 0;
        #2;
        chk("R6", {2'b00, dut_vec[31:0]}, 34'h0);   // cycle after load_en falls
        tick();
        #2;
        // term0 always true, term1 forced false, C0 high selects ELSE term4
        cur_req = "R1";
        chk("R1", {33'h0, st_j[0]}, 34'h1);
        chk("R1", {33'h0, st_k[0]}, 34'h0);
        cur_req = "R4";
        chk("R4", dut_vec, {2'b11, 8'h08, 8'h00, 8'h00, 8'h01});

        tick(); ext_in[5] = 1'b1;
        #2;
        chk("R4", dut_vec, {2'b10, 8'h00, 8'h08, 8'h00, 8'h01});

        // feedback index 16 and ext index 0, visible in same cycle
        cur_req = "R2";
        tick(); st_fb[0] = 1'b1; ext_in[0] = 1'b0;
        #2;
        chk("R2", {33'h0, out_j[0]}, 34'h1);
        #1; ext_in[0] = 1'b1; #0.5;
        chk("R8", {33'h0, out_j[0]}, 34'h0);

        // column pairing: J of state 0 from col 0, K of out 3 from col 23
        cur_req = "R3";
        tick(); ext_in = '0; st_fb = '0;
        #2;
        chk("R3", {26'h0, out_k}, {26'h0, 8'h08});

        // write without load enable is ignored
        cur_req = "R5";
        tick(); cfg_we = 1; cfg_addr = 6; cfg_wdata = mk(0, 0, 32'h1 << 30, 0);
        tick(); cfg_we = 0;
        tick();
        #1;
        chk("R5", {33'h0, out_j[7]}, 34'h0);

        // reset clears configuration
        cur_req = "R7";
        tick(); rst = 1; ext_in[5] = 1'b1;
        tick(); tick(); rst = 0;
        #2;
        chk("R7", dut_vec, {2'b11, 32'h0});

        // random configurations with mid-run reloads
        cur_req = "R3 R4";
        for (int k = 0; k < 3; k++) begin
            tick(); cfg_load_en = 1;
            for (int t = 0; t < N_TERM; t++) begin
                tick(); cfg_we = 1; cfg_addr = W_ADDR'(t); cfg_wdata = rnd_word();
            end
            tick(); cfg_we = 0; cfg_load_en = 0;
            for (int n = 0; n < 300; n++) begin
                tick();
                ext_in = N_IN'($urandom);
                st_fb  = N_FB'($urandom);
                if (n % 100 == 50) begin
                    cfg_load_en = 1; cfg_we = 1;
                    cfg_addr = W_ADDR'($urandom); cfg_wdata = rnd_word();
                end else if (n % 100 == 51) begin
                    cfg_we = 0; cfg_load_en = 0;
                end
            end
        end

        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule